// File: doc/BRIEF.md
# Supervisory Reset Timer Controller

This block turns digitised supply-supervision flags into one active-low system reset. It holds the reset output low until the main supply is reported good and the manual reset input is released. It then waits a programmed number of clock cycles before it lets the reset go. A supply or manual-reset condition that is recognised while reset is released pulls the output low at once, with no delay. Short dips on either input are filtered out, so they never reach the output.

The flag that says some supply has reached the minimum operating level acts as the block's asynchronous clear. The supply-good flag and the manual input are asynchronous. Each passes through a synchronizer chain, then a minimum-width filter, then the release timer. A separate comparator flag for power-fail reporting is passed straight through to its own output.

Top module: `sup_reset_ctl`

## Requirements
- R1: While `pwr_min_ok` is 0, `sys_rst_n` is 0 whatever the other inputs do. The release count does not start until `pwr_min_ok` is 1.
- R2: `sys_rst_n` goes to 1 only when the filtered supply flag and the filtered manual input are both 1. Counting edges from the first one at which both raw inputs are sampled high, it rises at edge DELAY_CYC+3 (two synchronizer stages, one filter stage, then DELAY_CYC good samples).
- R3: If `vdd_good` is held at 0 for GLITCH_CYC or more consecutive edges while released, `sys_rst_n` falls at edge GLITCH_CYC+3 after the drop. Once the input is high again, the output releases at edge L+3+DELAY_CYC, where L is the length of the dip in edges.
- R4: A `vdd_good` dip shorter than GLITCH_CYC edges has no effect on `sys_rst_n`.
- R5: If `man_rst_n` is held at 0 for MR_MIN_CYC or more consecutive edges, `sys_rst_n` falls at edge MR_MIN_CYC+3. It releases at edge L+3+DELAY_CYC.
- R6: A `man_rst_n` pulse shorter than MR_MIN_CYC edges has no effect, even while the release delay is counting.
- R7: A reset condition recognised while the delay is counting clears the count. The full DELAY_CYC delay starts again once both conditions are good.
- R8: `pfail_n` equals `pfail_cmp` at all times: 0 when the monitored input is below its threshold, 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock of known period |
| pwr_min_ok | input | 1 | 1 once any supply reaches the minimum operating level; 0 clears the block asynchronously |
| vdd_good | input | 1 | Asynchronous flag, 1 when the main supply is above the reset threshold |
| man_rst_n | input | 1 | Asynchronous active-low manual reset request |
| pfail_cmp | input | 1 | Power-fail comparator flag, 1 when the monitored input is above its threshold |
| sys_rst_n | output | 1 | Active-low system reset |
| pfail_n | output | 1 | Active-low power-fail indication |

## Verification
The bench sweeps the dip length on each input across the filter boundary, from one edge up to two edges past the minimum width. For each length it records the exact edge at which the reset falls and rises again. A filter that is off by one would either miss a legal dip or react to a short glitch. A missing synchronizer stage would shift every fall and release edge by one. A manual pulse is also injected partway through a release count. A timer that was not cleared would release early, and a timer that listened to short pulses would restart when it should not.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

   // Width of a counter that must hold the values 0 .. n-1.
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n)
               if (!arst_n) chain[0] <= 1'b0;
               else         chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n)
               if (!arst_n) chain[i] <= 1'b0;
               else         chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_deglitch.sv
module sup_deglitch
   import sup_rst_pkg::*;
#(
   parameter int MIN_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic din,
   output logic dout
);
   localparam int W = cnt_width(MIN_CYC);
   localparam logic [W-1:0] LAST = W'(MIN_CYC - 1);

   generate
      if (MIN_CYC < 1) begin : g_bad_min
         $error("sup_deglitch: MIN_CYC must be at least 1");
      end
      if (MIN_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) dout <= 1'b0;
            else         dout <= din;
      end else begin : g_counted
         logic [W-1:0] low_cnt;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               low_cnt <= '0;
               dout    <= 1'b0;
            end else if (din) begin
               low_cnt <= '0;
               dout    <= 1'b1;
            end else if (low_cnt == LAST) begin
               dout    <= 1'b0;
            end else begin
               low_cnt <= low_cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sup_rel_timer.sv
module sup_rel_timer
   import sup_rst_pkg::*;
#(
   parameter int DELAY_CYC = 20
) (
   input  logic clk,
   input  logic arst_n,
   input  logic all_ok,
   output logic released
);
   localparam int W = cnt_width(DELAY_CYC);
   localparam logic [W-1:0] LAST = W'(DELAY_CYC - 1);

   logic [W-1:0] cnt;

   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("sup_rel_timer: DELAY_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt      <= '0;
         released <= 1'b0;
      end else if (!all_ok) begin
         cnt      <= '0;
         released <= 1'b0;
      end else if (!released) begin
         if (cnt == LAST) released <= 1'b1;
         else             cnt      <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sup_reset_ctl.sv
module sup_reset_ctl #(
   parameter int DELAY_CYC   = 10_000_000,
   parameter int GLITCH_CYC  = 600,
   parameter int MR_MIN_CYC  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic pwr_min_ok,
   input  logic vdd_good,
   input  logic man_rst_n,
   input  logic pfail_cmp,
   output logic sys_rst_n,
   output logic pfail_n
);
   logic vdd_sync, mr_sync;
   logic vdd_flt, mr_flt;

   sup_sync #(.STAGES(SYNC_STAGES)) u_vdd_sync (
      .clk(clk), .arst_n(pwr_min_ok), .d(vdd_good), .q(vdd_sync));
   sup_sync #(.STAGES(SYNC_STAGES)) u_mr_sync (
      .clk(clk), .arst_n(pwr_min_ok), .d(man_rst_n), .q(mr_sync));

   sup_deglitch #(.MIN_CYC(GLITCH_CYC)) u_vdd_flt (
      .clk(clk), .arst_n(pwr_min_ok), .din(vdd_sync), .dout(vdd_flt));
   sup_deglitch #(.MIN_CYC(MR_MIN_CYC)) u_mr_flt (
      .clk(clk), .arst_n(pwr_min_ok), .din(mr_sync), .dout(mr_flt));

   sup_rel_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
      .clk(clk), .arst_n(pwr_min_ok), .all_ok(vdd_flt & mr_flt),
      .released(sys_rst_n));

   assign pfail_n = pfail_cmp;
endmodule

// File: rtl/sup_reset_ctl_chk.sv
module sup_reset_ctl_chk
   import sup_rst_pkg::*;
#(
   parameter int DELAY_CYC  = 20,
   parameter int GLITCH_CYC = 4
) (
   input logic clk,
   input logic pwr_min_ok,
   input logic vdd_s,
   input logic vdd_f,
   input logic mr_f,
   input logic rst_n_o
);
   localparam int GW = cnt_width(DELAY_CYC + 1);
   localparam int LW = cnt_width(GLITCH_CYC + 1);
   localparam logic [GW-1:0] GMAX = GW'(DELAY_CYC);
   localparam logic [LW-1:0] LMAX = LW'(GLITCH_CYC);

   logic [GW-1:0] good_run;
   logic [LW-1:0] low_run;

   always_ff @(posedge clk or negedge pwr_min_ok) begin
      if (!pwr_min_ok) begin
         good_run <= '0;
         low_run  <= '0;
      end else begin
         if (!(vdd_f && mr_f))   good_run <= '0;
         else if (good_run != GMAX) good_run <= good_run + 1'b1;
         if (vdd_s)              low_run <= '0;
         else if (low_run != LMAX) low_run <= low_run + 1'b1;
      end
   end

   p_rel_needs_both_r2: assert property (@(posedge clk) disable iff (!pwr_min_ok)
      $rose(rst_n_o) |-> $past(vdd_f && mr_f));

   p_full_delay_r7: assert property (@(posedge clk) disable iff (!pwr_min_ok)
      $rose(rst_n_o) |-> (good_run == GMAX));

   p_supply_drop_r3: assert property (@(posedge clk) disable iff (!pwr_min_ok)
      !vdd_f |=> !rst_n_o);

   p_manual_drop_r5: assert property (@(posedge clk) disable iff (!pwr_min_ok)
      !mr_f |=> !rst_n_o);

   p_dip_width_r4: assert property (@(posedge clk) disable iff (!pwr_min_ok)
      $fell(vdd_f) |-> (low_run == LMAX));
endmodule

bind sup_reset_ctl sup_reset_ctl_chk #(
   .DELAY_CYC(DELAY_CYC), .GLITCH_CYC(GLITCH_CYC)
) u_chk (
   .clk(clk), .pwr_min_ok(pwr_min_ok), .vdd_s(vdd_sync),
   .vdd_f(vdd_flt), .mr_f(mr_flt), .rst_n_o(sys_rst_n)
);

// File: tb/sup_reset_ctl_test.sv
module sup_reset_ctl_test;
   localparam int CLK_NS = 10;
   localparam int D = 20;
   localparam int G = 4;
   localparam int M = 3;

   logic clk = 1'b0;
   logic pwr_min_ok, vdd_good, man_rst_n, pfail_cmp;
   logic sys_rst_n, pfail_n;
   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   sup_reset_ctl #(.DELAY_CYC(D), .GLITCH_CYC(G), .MR_MIN_CYC(M), .SYNC_STAGES(2)) uut (
      .clk(clk), .pwr_min_ok(pwr_min_ok), .vdd_good(vdd_good),
      .man_rst_n(man_rst_n), .pfail_cmp(pfail_cmp),
      .sys_rst_n(sys_rst_n), .pfail_n(pfail_n));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Drop one input for L edges, then report first fall / rise edge.
   task automatic dip(input bit is_mr, input int L, output int first_low, output int first_rise);
      first_low = -1;
      first_rise = -1;
      if (is_mr) man_rst_n = 1'b0; else vdd_good = 1'b0;
      for (int e = 1; e <= L + D + 10; e++) begin
         @(negedge clk);
         if (!sys_rst_n && first_low < 0) first_low = e;
         if (sys_rst_n && first_low >= 0 && first_rise < 0) first_rise = e;
         if (e == L) begin
            if (is_mr) man_rst_n = 1'b1; else vdd_good = 1'b1;
         end
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int fl, fr;
      pwr_min_ok = 1'b0; vdd_good = 1'b0; man_rst_n = 1'b1; pfail_cmp = 1'b0;
      cyc(3);
      chk("R1 reset state", sys_rst_n, 0);
      vdd_good = 1'b1;
      cyc(3 * D);
      chk("R1 held while minimum supply absent", sys_rst_n, 0);

      // R8 pass-through
      for (int v = 0; v < 2; v++) begin
         pfail_cmp = v[0];
         #1;
         chk("R8 power-fail follows comparator", pfail_n, v);
      end

      // R2 first release: inputs already high, clear lifted at this negedge
      pwr_min_ok = 1'b1;
      cyc(D + 2);
      chk("R2 still held one edge before release", sys_rst_n, 0);
      cyc(1);
      chk("R2 released at edge D+3", sys_rst_n, 1);

      // R3 / R4 supply dip sweep
      for (int L = 1; L <= G + 2; L++) begin
         dip(1'b0, L, fl, fr);
         if (L >= G) begin
            chk("R3 supply drop edge", fl, G + 3);
            chk("R3 supply re-release edge", fr, L + 3 + D);
         end else begin
            chk("R4 short supply dip ignored", fl, -1);
         end
      end

      // R5 / R6 manual pulse sweep
      for (int L = 1; L <= M + 2; L++) begin
         dip(1'b1, L, fl, fr);
         if (L >= M) begin
            chk("R5 manual drop edge", fl, M + 3);
            chk("R5 manual re-release edge", fr, L + 3 + D);
         end else begin
            chk("R6 short manual pulse ignored", fl, -1);
         end
      end

      // R2: supply good but manual held low never releases
      man_rst_n = 1'b0;
      cyc(3 * D);
      chk("R2 no release with manual low", sys_rst_n, 0);
      man_rst_n = 1'b1;
      cyc(D + 2);
      chk("R2 held before delay after manual release", sys_rst_n, 0);
      cyc(1);
      chk("R2 release after manual returns", sys_rst_n, 1);

      // R7 / R6 during counting: supply dip, then manual pulse mid-count
      for (int k = 0; k < 2; k++) begin
         int plen, s;
         plen = (k == 0) ? M : M - 1;
         vdd_good = 1'b0;
         cyc(G + 2);
         vdd_good = 1'b1;
         // input high before edge G+3 counted from here; flt high at edge 3
         fl = -1; fr = -1;
         s = 8;
         for (int e = 1; e <= s + plen + D + 12; e++) begin
            @(negedge clk);
            if (sys_rst_n && fr < 0) fr = e;
            if (e == s) man_rst_n = 1'b0;
            if (e == s + plen) man_rst_n = 1'b1;
         end
         if (k == 0) chk("R7 count restarts after manual reset", fr, s + plen + 3 + D);
         else        chk("R6 short pulse mid-count leaves delay", fr, 3 + D);
      end

      // R1: asynchronous clear forces reset low immediately
      #2;
      pwr_min_ok = 1'b0;
      #1;
      chk("R1 asynchronous clear", sys_rst_n, 0);
      @(negedge clk);
      pwr_min_ok = 1'b1;
      cyc(D + 3);
      chk("R1 release after clear lifted", sys_rst_n, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule